// File: doc/BRIEF.md
# Bit-Sliced Multi-Channel PWM Generator

This block drives four pulse-width-modulated outputs. Each output is controlled by two free-running 5-bit down-counters. One counter's underflow turns the output on and the other's underflow turns it off. The eight counters are not stored as eight separate words. They are kept transposed as five 8-bit bit-plane registers, and each plane holds one bit weight of every counter. A single shared ripple chain decrements all eight counters together whenever the tick enable is high.

Every counter wraps from 0 to 31, so every channel has a period of 32 ticks. A channel's phase comes from the preset of its rising-edge counter. Its duty comes from the distance between its rising and falling presets. Presets are written one counter at a time through a synchronous load port. Lanes 0 to 3 are the rising-edge counters of channels 0 to 3. Lanes 4 to 7 are the falling-edge counters of those same channels.

Top module: `slice_pwm`

## Requirements
- R1: While rstN is low, pwmOut is 0 and every counter is 0. The first tick after reset therefore underflows all eight lanes at once, and pwmOut stays 0.
- R2: In a cycle with tickEn low, neither the counters nor pwmOut change, except for a lane being loaded.
- R3: On each tick, every lane that is not being loaded decrements by one. A lane at 0 wraps to 31 and reports an underflow.
- R4: When rising lane i (0..3) underflows on a tick and its falling lane does not, pwmOut[i] is 1 after that clock edge.
- R5: When falling lane i+4 underflows on a tick, pwmOut[i] is 0 after that clock edge.
- R6: When lanes i and i+4 underflow on the same tick, the clear wins and pwmOut[i] is 0.
- R7: With loadEn high, loadValue (5 bits) is written into the lane given by loadLane (3 bits, values 0..7). The next tick decrements the lane starting from that preset.
- R8: If loadEn and tickEn are high in the same cycle, the loaded lane takes the preset without decrementing or reporting an underflow. All other lanes count normally.
- R9: Set rising preset r and falling preset f for a channel and let 32 ticks pass. Over any following 32 ticks, the output is high for exactly (f - r) mod 32 ticks. It goes high r+1 ticks after the load.
- R10: A load never changes pwmOut by itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Count enable; one decrement of all lanes per high cycle |
| loadEn | input | 1 | Write a preset into one lane this cycle |
| loadLane | input | 3 | Target lane: 0..3 rising counters, 4..7 falling counters |
| loadValue | input | 5 | Preset count written to the target lane |
| pwmOut | output | 4 | PWM outputs, one bit per channel |

## Verification
The assertions check, on every cycle, the per-lane arithmetic of the transposed planes. That covers the decrement with wraparound, a counter holding when there is no tick, and a preset landing in the right lane. They also check that each underflow reaches its output with the right polarity, and that the clear takes precedence. Only the bench scenarios show the effects that build up over many ticks. Those are the duty and phase produced by each pair of presets, the all-lane underflow after reset, and a load colliding with a tick. The bench sweeps all 1024 rising/falling preset pairs across the four channels and compares each tick against an arithmetic model.

// File: rtl/slice_pwm_pkg.sv
package slice_pwm_pkg;
  parameter int NUM_CH = 4;
  parameter int CNT_W  = 5;
  localparam int LANES  = 2 * NUM_CH;
  localparam int LANE_W = $clog2(LANES);

  typedef struct packed {
    logic             tick;
    logic             load;
    logic [LANES-1:0] laneMask;
    logic [CNT_W-1:0] value;
  } strobe_t;
endpackage

// File: rtl/slice_pwm_ctrl.sv
module slice_pwm_ctrl
  import slice_pwm_pkg::*;
(
  input  logic              tickEn,
  input  logic              loadEn,
  input  logic [LANE_W-1:0] loadLane,
  input  logic [CNT_W-1:0]  loadValue,
  output strobe_t           strb
);
  logic [LANES-1:0] laneDec;

  // one-hot lane select for the load port
  for (genvar l = 0; l < LANES; l++) begin : g_dec
    assign laneDec[l] = loadEn && (loadLane == LANE_W'(l));
  end

  always_comb begin
    strb          = '0;
    strb.tick     = tickEn;
    strb.load     = loadEn;
    strb.laneMask = laneDec;
    strb.value    = loadValue;
  end
endmodule

// File: rtl/slice_pwm_dp.sv
module slice_pwm_dp
  import slice_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  output logic [NUM_CH-1:0] pwmOut
);
  // planes[n] holds bit weight n of every lane
  logic [CNT_W-1:0][LANES-1:0] planes;
  logic [CNT_W-1:0][LANES-1:0] planesNext;
  logic [CNT_W:0][LANES-1:0]   carry;
  logic [LANES-1:0]            underflow;
  logic [NUM_CH-1:0]           riseHit, fallHit;
  logic [LANES-1:0][CNT_W-1:0] laneCount;

  // ripple chain: a lane whose bit goes 0 -> 1 borrows into the next plane
  assign carry[0] = {LANES{strb.tick}};
  for (genvar n = 0; n < CNT_W; n++) begin : g_plane
    logic [LANES-1:0] counted;
    assign counted       = planes[n] ^ carry[n];
    assign carry[n+1]    = carry[n] & ~planes[n];
    assign planesNext[n] = (counted & ~strb.laneMask)
                         | (strb.laneMask & {LANES{strb.value[n]}});
  end

  // a lane overwritten by a load does not report an underflow
  assign underflow = carry[CNT_W] & ~strb.laneMask;
  assign riseHit   = underflow[NUM_CH-1:0];
  assign fallHit   = underflow[LANES-1:NUM_CH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      planes <= '0;
      pwmOut <= '0;
    end else begin
      planes <= planesNext;
      pwmOut <= (pwmOut | riseHit) & ~fallHit;
    end
  end

  // per-lane view of the transposed counters
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar n = 0; n < CNT_W; n++) begin : g_bit
      assign laneCount[l][n] = planes[n][l];
    end

    // R3
    dec_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.tick && !strb.laneMask[l]) |=>
        (laneCount[l] == $past(laneCount[l]) - CNT_W'(1)));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.tick && !strb.laneMask[l]) |=> $stable(laneCount[l]));

    // R7
    preset_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.laneMask[l] |=> (laneCount[l] == $past(strb.value)));
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_out
    // R4
    rise_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
      (riseHit[i] && !fallHit[i]) |=> pwmOut[i]);

    // R5 R6
    fall_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
      fallHit[i] |=> !pwmOut[i]);
  end

  // R2 R10
  out_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tick |=> $stable(pwmOut));
endmodule

// File: rtl/slice_pwm.sv
module slice_pwm
  import slice_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              loadEn,
  input  logic [LANE_W-1:0] loadLane,
  input  logic [CNT_W-1:0]  loadValue,
  output logic [NUM_CH-1:0] pwmOut
);
  strobe_t strb;

  slice_pwm_ctrl u_ctrl (
    .tickEn   (tickEn),
    .loadEn   (loadEn),
    .loadLane (loadLane),
    .loadValue(loadValue),
    .strb     (strb)
  );

  slice_pwm_dp u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .pwmOut(pwmOut)
  );
endmodule

// File: tb/slice_pwm_tb.sv
module slice_pwm_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       loadEn = 1'b0;
  logic [2:0] loadLane = '0;
  logic [4:0] loadValue = '0;
  logic [3:0] pwmOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [4:0] mCnt [8];
  logic [3:0] mOut;

  always #2 clk = ~clk;

  slice_pwm u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .loadEn(loadEn),
    .loadLane(loadLane), .loadValue(loadValue), .pwmOut(pwmOut)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // arithmetic reference: one clock edge
  task automatic modelEdge(input bit t, input bit ld, input int lane, input int val);
    logic [7:0] uf = '0;
    for (int l = 0; l < 8; l++) begin
      if (ld && l == lane) mCnt[l] = 5'(val);
      else if (t) begin
        uf[l] = (mCnt[l] == 0);
        mCnt[l] = mCnt[l] - 5'd1;
      end
    end
    mOut = (mOut | uf[3:0]) & ~uf[7:4];
  endtask

  // called at a negedge; drives one cycle and compares at the next negedge
  task automatic step(input bit t, input bit ld, input int lane, input int val, input string req);
    tickEn = t; loadEn = ld; loadLane = 3'(lane); loadValue = 5'(val);
    @(posedge clk);
    modelEdge(t, ld, lane, val);
    @(negedge clk);
    tickEn = 0; loadEn = 0;
    check(32'(pwmOut), 32'(mOut), req);
  endtask

  task automatic doReset();
    rstN = 0;
    for (int l = 0; l < 8; l++) mCnt[l] = '0;
    mOut = '0;
    @(negedge clk); @(negedge clk);
    check(32'(pwmOut), 0, "R1");
    rstN = 1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int highs [4];
    for (int l = 0; l < 8; l++) mCnt[l] = '0;
    mOut = '0;
    @(negedge clk);
    doReset();

    // R1: first tick underflows all lanes, coincident rise/fall keeps low (R6)
    step(1, 0, 0, 0, "R1 R6");
    check(32'(pwmOut), 0, "R1");
    // R2: idle cycles leave outputs alone
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, "R2");

    // directed: rise lane 1 = 2, fall lane 5 = 6 -> high after tick 3, low after tick 7
    doReset();
    step(0, 1, 1, 2, "R7 R10");
    step(0, 1, 5, 6, "R7 R10");
    for (int l = 0; l < 8; l++) if (l != 1 && l != 5) step(0, 1, l, 20, "R7 R10");
    step(1, 0, 0, 0, "R3"); step(1, 0, 0, 0, "R3");
    check(32'(pwmOut[1]), 0, "R4");
    step(1, 0, 0, 0, "R4");
    check(32'(pwmOut[1]), 1, "R4");
    step(0, 0, 0, 0, "R2");
    check(32'(pwmOut[1]), 1, "R2");
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0, "R3 R5");
    check(32'(pwmOut[1]), 0, "R5");

    // R8: load collides with tick; lane 1 takes 0, others count
    step(1, 1, 1, 0, "R8");
    step(1, 0, 0, 0, "R8");
    check(32'(pwmOut[1]), 1, "R8");

    // R9: sweep every rising/falling preset pair, four channels at a time
    for (int cfg = 0; cfg < 256; cfg++) begin
      for (int c = 0; c < 4; c++) begin
        int idx = cfg * 4 + c;
        step(0, 1, c, idx % 32, "R7 R10");
        step(0, 1, c + 4, idx / 32, "R7 R10");
      end
      for (int c = 0; c < 4; c++) highs[c] = 0;
      for (int k = 1; k <= 64; k++) begin
        step(1, 0, 0, 0, "R3 R4 R5 R6");
        if (k > 32) for (int c = 0; c < 4; c++) highs[c] += int'(pwmOut[c]);
        step(0, 0, 0, 0, "R2");
      end
      for (int c = 0; c < 4; c++) begin
        int idx = cfg * 4 + c;
        check(32'(highs[c]), 32'(((idx / 32) - (idx % 32) + 32) % 32), "R9");
      end
    end

    doReset();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule